// File: doc/BRIEF.md
# Delta-Sigma Converter Result Frame Decoder

This block reads one 32-bit result frame from an external delta-sigma converter over a three-wire serial link and turns it into decoded fields. A start request pulls chip select low. The block then generates a divided serial clock and shifts the frame in, most significant bit first. After the last bit it releases chip select and splits the frame into three parts: the status bits, a 24-bit magnitude field and the sub-LSB tail.

In each frame, the third bit is the sign. That bit together with the top bit of the 24-bit field marks an input outside the bipolar span of plus or minus half the reference. The block raises an overrange or underrange flag for these cases. It also forms a 25-bit two's-complement sample that saturates to the full-scale codes outside the span. This sample is sign-extended to the output width and presented with a one-cycle valid strobe.

A frame whose leading conversion-state bit reads 1 is not a finished conversion. Such a frame is dropped and a not-ready flag is raised instead.

Top module: `sdadc_frame_rx`

## Requirements
- R1: After a synchronous reset, chip select (active low) is high, the serial clock is low, and busy, the valid strobe and the not-ready flag are all low.
- R2: A start request seen while idle drives chip select low and busy high on the next clock edge. Chip select stays low until exactly 32 rising serial clock edges have occurred. A start request seen while busy is ignored.
- R3: Each high phase and each low phase of the serial clock lasts HALF_DIV system clocks. The serial data line is sampled on each rising serial clock edge.
- R4: The channel output is frame bit 30. The raw result output is frame bits 28 down to 5. The sub-LSB output is frame bits 4 down to 0. Frame bit 31 is the first bit received.
- R5: The overrange flag is set when the sign bit (frame bit 29) is 1 and the result MSB (frame bit 28) is 1.
- R6: The underrange flag is set when the sign bit and the result MSB are both 0. The two range flags are never set together.
- R7: For an in-range frame, the sample is the 25-bit value formed by the inverted sign bit followed by the 24 result bits, sign-extended to SAMPLE_W bits. Sign 1 means a non-negative value.
- R8: On overrange, the sample is +2^23. On underrange, the sample is −2^23. Both are sign-extended to SAMPLE_W bits.
- R9: When frame bit 31 is 1, no valid strobe is issued and all decoded outputs keep their previous values. The not-ready flag goes high, and it stays high until the next accepted start request clears it.
- R10: The valid strobe lasts one cycle. It rises on the same edge on which busy falls and chip select returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| startReq | input | 1 | Request to read one frame |
| sdi | input | 1 | Serial data from the converter |
| sclk | output | 1 | Generated serial clock |
| csN | output | 1 | Chip select, active low |
| busy | output | 1 | High from accepted start until the valid strobe edge |
| sampleValid | output | 1 | One-cycle strobe for a decoded frame |
| sample | output | SAMPLE_W | Sign-extended two's-complement sample |
| resultRaw | output | 24 | Raw 24-bit result field |
| subLsb | output | 5 | Sub-LSB bits |
| chanSel | output | 1 | Channel status bit |
| signBit | output | 1 | Sign status bit |
| overRange | output | 1 | Input above positive full scale |
| underRange | output | 1 | Input below negative full scale |
| notReady | output | 1 | Last frame had conversion-state bit set |

## Verification
Random frames with the conversion bit mostly clear test field splitting and in-range sign handling across the whole code space. Directed frames cover the four combinations of sign and result MSB: the two saturation codes, the in-range extremes +2^23−1 and −2^23, zero and −1. These separate a correct range decode from one that swaps the flag polarity or skips saturation. Frames with the conversion bit set are checked to leave earlier outputs untouched, and a start request pulsed mid-transfer is checked to change neither the edge count nor the strobe count.

// File: rtl/sdadc_frame_pkg.sv
package sdadc_frame_pkg;
  localparam int FRAME_W  = 32;
  localparam int RES_W    = 24;
  localparam int SUB_W    = 5;
  localparam int CORE_W   = RES_W + 1;
  localparam int EOC_POS  = FRAME_W - 1;
  localparam int CHAN_POS = FRAME_W - 2;
  localparam int SIGN_POS = FRAME_W - 3;
  localparam int RES_MSB  = SIGN_POS - 1;
  localparam int RES_LSB  = RES_MSB - RES_W + 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DONE  = 2'd2
  } rxState_e;

  typedef struct packed {
    logic clear;
    logic shift;
    logic load;
  } dpCtl_t;
endpackage

// File: rtl/sdadc_frame_ctrl.sv
module sdadc_frame_ctrl
  import sdadc_frame_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   startReq,
  output logic   sclk,
  output logic   csN,
  output logic   busy,
  output dpCtl_t dpCtl
);
  localparam int DIV_W = $clog2(HALF_DIV + 1);
  localparam int BIT_W = $clog2(FRAME_W + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W);

  rxState_e          state;
  logic [DIV_W-1:0]  divCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic              phaseEnd;

  assign phaseEnd = (state == ST_SHIFT) && (divCnt == DIV_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      divCnt <= '0;
      bitCnt <= '0;
      sclk   <= 1'b0;
      csN    <= 1'b1;
      busy   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startReq) begin
            state  <= ST_SHIFT;
            csN    <= 1'b0;
            busy   <= 1'b1;
            divCnt <= '0;
            bitCnt <= '0;
            sclk   <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (phaseEnd) begin
            divCnt <= '0;
            sclk   <= ~sclk;
            if (!sclk) begin
              bitCnt <= bitCnt + 1'b1;
            end else if (bitCnt == BIT_LAST) begin
              state <= ST_DONE;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_DONE: begin
          state <= ST_IDLE;
          csN   <= 1'b1;
          busy  <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    dpCtl.clear = (state == ST_IDLE) && startReq;
    dpCtl.shift = phaseEnd && !sclk;
    dpCtl.load  = (state == ST_DONE);
  end
endmodule

// File: rtl/sdadc_frame_dp.sv
module sdadc_frame_dp
  import sdadc_frame_pkg::*;
#(
  parameter int SAMPLE_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sdi,
  input  dpCtl_t              dpCtl,
  output logic                sampleValid,
  output logic [SAMPLE_W-1:0] sample,
  output logic [RES_W-1:0]    resultRaw,
  output logic [SUB_W-1:0]    subLsb,
  output logic                chanSel,
  output logic                signBit,
  output logic                overRange,
  output logic                underRange,
  output logic                notReady
);
  localparam logic [CORE_W-1:0] POS_FS = CORE_W'(1) << (RES_W - 1);
  localparam logic [CORE_W-1:0] NEG_FS = ~POS_FS + 1'b1;

  logic [FRAME_W-1:0] shiftReg;
  logic [CORE_W-1:0]  coreReg;
  logic [CORE_W-1:0]  coreNext;
  logic               frmSign;
  logic               frmMsb;
  logic               frmOver;
  logic               frmUnder;

  assign frmSign  = shiftReg[SIGN_POS];
  assign frmMsb   = shiftReg[RES_MSB];
  assign frmOver  = frmSign && frmMsb;
  assign frmUnder = !frmSign && !frmMsb;

  always_comb begin
    if (frmOver)       coreNext = POS_FS;
    else if (frmUnder) coreNext = NEG_FS;
    else               coreNext = {~frmSign, shiftReg[RES_MSB:RES_LSB]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg    <= '0;
      coreReg     <= '0;
      resultRaw   <= '0;
      subLsb      <= '0;
      chanSel     <= 1'b0;
      signBit     <= 1'b0;
      overRange   <= 1'b0;
      underRange  <= 1'b0;
      notReady    <= 1'b0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= 1'b0;
      if (dpCtl.clear) begin
        shiftReg <= '0;
        notReady <= 1'b0;
      end else if (dpCtl.shift) begin
        shiftReg <= {shiftReg[FRAME_W-2:0], sdi};
      end else if (dpCtl.load) begin
        if (shiftReg[EOC_POS]) begin
          notReady <= 1'b1;
        end else begin
          coreReg     <= coreNext;
          resultRaw   <= shiftReg[RES_MSB:RES_LSB];
          subLsb      <= shiftReg[SUB_W-1:0];
          chanSel     <= shiftReg[CHAN_POS];
          signBit     <= frmSign;
          overRange   <= frmOver;
          underRange  <= frmUnder;
          sampleValid <= 1'b1;
        end
      end
    end
  end

  generate
    if (SAMPLE_W > CORE_W) begin : g_ext
      assign sample = {{(SAMPLE_W - CORE_W){coreReg[CORE_W-1]}}, coreReg};
    end else begin : g_noext
      assign sample = coreReg[SAMPLE_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/sdadc_frame_rx.sv
module sdadc_frame_rx
  import sdadc_frame_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int SAMPLE_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                startReq,
  input  logic                sdi,
  output logic                sclk,
  output logic                csN,
  output logic                busy,
  output logic                sampleValid,
  output logic [SAMPLE_W-1:0] sample,
  output logic [23:0]         resultRaw,
  output logic [4:0]          subLsb,
  output logic                chanSel,
  output logic                signBit,
  output logic                overRange,
  output logic                underRange,
  output logic                notReady
);
  dpCtl_t dpCtl;

  sdadc_frame_ctrl #(.HALF_DIV(HALF_DIV)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .startReq (startReq),
    .sclk     (sclk),
    .csN      (csN),
    .busy     (busy),
    .dpCtl    (dpCtl)
  );

  sdadc_frame_dp #(.SAMPLE_W(SAMPLE_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .sdi         (sdi),
    .dpCtl       (dpCtl),
    .sampleValid (sampleValid),
    .sample      (sample),
    .resultRaw   (resultRaw),
    .subLsb      (subLsb),
    .chanSel     (chanSel),
    .signBit     (signBit),
    .overRange   (overRange),
    .underRange  (underRange),
    .notReady    (notReady)
  );
endmodule

// File: rtl/sdadc_frame_chk.sv
module sdadc_frame_chk #(
  parameter int SAMPLE_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                sclk,
  input logic                csN,
  input logic                busy,
  input logic                sampleValid,
  input logic [SAMPLE_W-1:0] sample,
  input logic                overRange,
  input logic                underRange,
  input logic                notReady
);
  localparam logic [SAMPLE_W-1:0] POS_FS = SAMPLE_W'(1) << 23;
  localparam logic [SAMPLE_W-1:0] NEG_FS = ~POS_FS + 1'b1;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (csN && !sclk));

  p_sclk_in_cs_r2: assert property (@(posedge clk) disable iff (rst)
    sclk |-> !csN);

  p_flags_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(overRange && underRange));

  p_sat_pos_r8: assert property (@(posedge clk) disable iff (rst)
    (sampleValid && overRange) |-> (sample == POS_FS));

  p_sat_neg_r8: assert property (@(posedge clk) disable iff (rst)
    (sampleValid && underRange) |-> (sample == NEG_FS));

  p_ready_on_valid_r9: assert property (@(posedge clk) disable iff (rst)
    sampleValid |-> !notReady);

  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    sampleValid |=> !sampleValid);

  p_valid_ends_busy_r10: assert property (@(posedge clk) disable iff (rst)
    sampleValid |-> (!busy && $past(busy) && csN));
endmodule

bind sdadc_frame_rx sdadc_frame_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sclk        (sclk),
  .csN         (csN),
  .busy        (busy),
  .sampleValid (sampleValid),
  .sample      (sample),
  .overRange   (overRange),
  .underRange  (underRange),
  .notReady    (notReady)
);

// File: tb/sdadc_frame_rx_bench.sv
module sdadc_frame_rx_bench;
  localparam int HALF = 4;
  localparam int SW   = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          startReq = 1'b0;
  logic          sdi = 1'b0;
  logic          sclk, csN, busy, sampleValid;
  logic [SW-1:0] sample;
  logic [23:0]   resultRaw;
  logic [4:0]    subLsb;
  logic          chanSel, signBit, overRange, underRange, notReady;

  int checks = 0;
  int errors = 0;
  int bitIdx = 0;
  int riseCnt = 0;
  logic [31:0] curFrame = '0;

  always #4 clk = ~clk;

  sdadc_frame_rx #(.HALF_DIV(HALF), .SAMPLE_W(SW)) u_sdadc_frame_rx (
    .clk(clk), .rst(rst), .startReq(startReq), .sdi(sdi),
    .sclk(sclk), .csN(csN), .busy(busy), .sampleValid(sampleValid),
    .sample(sample), .resultRaw(resultRaw), .subLsb(subLsb),
    .chanSel(chanSel), .signBit(signBit), .overRange(overRange),
    .underRange(underRange), .notReady(notReady)
  );

  // converter model: next bit appears after each falling serial clock edge
  always @(negedge sclk) begin
    bitIdx++;
    if (bitIdx < 32) sdi = curFrame[31 - bitIdx];
  end

  always @(posedge sclk) riseCnt++;

  task automatic check(input bit ok, input string tag,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R3: phase length monitor while chip select is low
  logic pSclk = 1'b0;
  int   runLen = 0;
  always @(negedge clk) begin
    if (!rst && !csN) begin
      if (runLen == 0) begin
        runLen = 1;
      end else if (sclk != pSclk) begin
        check(runLen == HALF, "R3 phase length", runLen, HALF);
        runLen = 1;
      end else begin
        runLen++;
      end
    end else begin
      runLen = 0;
    end
    pSclk = sclk;
  end

  function automatic logic [SW-1:0] expSample(input logic [31:0] f);
    int v;
    logic s, m;
    s = f[29];
    m = f[28];
    if (s && m)        v = 1 << 23;              // R8
    else if (!s && !m) v = -(1 << 23);           // R8
    else if (s)        v = int'(f[28:5]);        // R7
    else               v = int'(f[28:5]) - (1 << 24);
    return SW'(v);
  endfunction

  task automatic runFrame(input logic [31:0] f, input bit midStart);
    logic [SW-1:0] oldSample;
    logic [23:0]   oldRaw;
    logic [4:0]    oldSub;
    int            n;
    oldSample = sample;
    oldRaw    = resultRaw;
    oldSub    = subLsb;
    curFrame  = f;
    bitIdx    = 0;
    riseCnt   = 0;
    sdi       = f[31];
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    check(!csN && busy, "R2 start accepted", {csN, busy}, 2'b01);
    check(!notReady, "R9 notReady cleared by start", notReady, 0);
    n = 0;
    while (busy && n < 2000) begin
      @(negedge clk);
      n++;
      if (midStart && n == 20) startReq = 1'b1;
      if (midStart && n == 21) startReq = 1'b0;
    end
    check(riseCnt == 32, "R2 rising edge count", riseCnt, 32);
    check(csN, "R10 chip select released", csN, 1);
    if (!f[31]) begin
      check(sampleValid, "R10 valid with busy fall", sampleValid, 1);
      check(chanSel == f[30], "R4 channel", chanSel, f[30]);
      check(signBit == f[29], "R4 sign", signBit, f[29]);
      check(resultRaw == f[28:5], "R4 raw result", resultRaw, f[28:5]);
      check(subLsb == f[4:0], "R4 sub-LSB", subLsb, f[4:0]);
      check(overRange == (f[29] & f[28]), "R5 overrange", overRange, f[29] & f[28]);
      check(underRange == (~f[29] & ~f[28]), "R6 underrange", underRange, ~f[29] & ~f[28]);
      check(sample == expSample(f), "R7 R8 sample", sample, expSample(f));
      @(negedge clk);
      check(!sampleValid, "R10 single-cycle valid", sampleValid, 0);
    end else begin
      check(!sampleValid, "R9 no valid when not ready", sampleValid, 1'b0);
      check(notReady, "R9 notReady raised", notReady, 1);
      check(sample == oldSample && resultRaw == oldRaw && subLsb == oldSub,
            "R9 outputs held", sample, oldSample);
      @(negedge clk);
      check(!sampleValid && notReady, "R9 still no valid", sampleValid, 0);
    end
    if (midStart) check(!busy, "R2 mid-transfer start ignored", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] f;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(csN && !sclk && !busy && !sampleValid && !notReady, "R1 reset state",
          {csN, sclk, busy, sampleValid, notReady}, 5'b10000);

    runFrame(32'h3FFF_FFE0, 1'b0);   // sign1 msb1: overrange R5 R8
    runFrame(32'h0000_001F, 1'b0);   // sign0 msb0: underrange R6 R8
    runFrame(32'h2FFF_FFFF, 1'b0);   // +2^23-1 in range R7
    runFrame(32'h1000_0000, 1'b0);   // -2^23 in range R7
    runFrame(32'h2000_0000, 1'b0);   // zero R7
    runFrame(32'h5FFF_FFE5, 1'b0);   // -1, channel 1 R4 R7
    runFrame(32'hA123_4567, 1'b0);   // not ready R9
    runFrame(32'h2ABC_DEF3, 1'b1);   // start during transfer R2
    runFrame(32'hFFFF_FFFF, 1'b0);   // not ready again R9
    for (int i = 0; i < 40; i++) begin
      f = $urandom();
      f[31] = (($urandom() % 8) == 0);
      runFrame(f, (i % 10) == 3);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule